// File: doc/BRIEF.md
# Pulse-Width Modulator Channel with Staged Configuration

This block produces one left-aligned pulse-width modulated output. Software reaches it over a small valid/write register bus. The bus holds three words: control, period and duty. A fixed prescaler divides the input clock into ticks. A counter advances once per tick through one period. The output sits at its active level while the counter is below the duty count, and at the opposite level for the rest of the period.

Period, duty and the two polarity bits are staged. The waveform is driven by a separate running copy of them. That copy is refreshed only at a period wrap, so a write never disturbs the period in progress. A hold bit in the control word stops this refresh entirely. Software can set the hold bit, rewrite period and duty, and then clear the hold in the same control write that changes polarity. The new period, duty and polarity all start together at the next period. While the channel is stopped, the counter rests at zero and the output shows the programmed idle level.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the control word reads 4 (run=0, hold=0, active-high=1, idle-high=0). Period and duty read 0, and the output is 0.
- R2: Control sits at word address 0, period at 1 and duty at 2. A read returns the value last written there. Control bits above bit 3 read 0, and address 3 reads 0.
- R3: Control bit 0 (run) starts the channel. From the cycle after the enabling write, each count lasts PRESCALE clocks. The output is active for duty×PRESCALE clocks and inactive until period×PRESCALE clocks have passed, then the pattern repeats. A period of 0 behaves as 1.
- R4: A duty of 0 gives a constant inactive output. A duty greater than or equal to the period gives a constant active output.
- R5: With run=0 the counter is held at zero. Within two clocks the output shows the idle level (control bit 3). On the next start, the waveform begins with a full active phase.
- R6: With the hold bit clear, a write to period, duty or polarity while running takes effect at the first period boundary that comes at least two clocks after the write cycle. It never takes effect mid-period.
- R7: While control bit 1 (hold) is set, writes to period and duty leave the waveform unchanged across any number of period boundaries.
- R8: A single control write that clears hold and changes polarity makes the staged period, duty and polarity start together at the next period boundary.
- R9: Control bit 2 selects the active level: 1 gives active-high, and 0 gives active-low with the inactive phase high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench targets the boundary timing of staged updates. A write made two clocks before a wrap must land at that wrap. A write made one clock before a wrap must wait a full extra period. A design that copies staged values mid-period, or that misjudges that final clock, shifts the expected waveform by one period.

A held configuration is driven across two wraps and then released together with a polarity flip. A design that leaks period or duty through the hold, or applies polarity separately from the counts, produces an intermediate waveform.

Duty of zero, duty at or above the period, and a period of one catch off-by-one errors in the compare and the wrap. A restart after a stop checks that the counter really returned to zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int unsigned ADR_CTRL   = 0;
   localparam int unsigned ADR_PERIOD = 1;
   localparam int unsigned ADR_DUTY   = 2;
   localparam int unsigned CB_RUN     = 0;
   localparam int unsigned CB_HOLD    = 1;
   localparam int unsigned CB_ACTHI   = 2;
   localparam int unsigned CB_IDLEHI  = 3;

   typedef struct packed {
      logic idle_hi;
      logic act_hi;
      logic hold;
      logic run;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{idle_hi: 1'b0, act_hi: 1'b1, hold: 1'b0, run: 1'b0};
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
   import pwm_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output ctrl_t             ctrl_o,
   output logic [CNT_W-1:0]  period_o,
   output logic [CNT_W-1:0]  duty_o
);
   localparam int unsigned PAD_W = DATA_W - CNT_W;

   logic wr_en;
   assign wr_en = valid_i && write_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_o   <= CTRL_RESET;
         period_o <= '0;
         duty_o   <= '0;
      end else if (wr_en) begin
         case (addr_i)
            ADDR_W'(ADR_CTRL): begin
               ctrl_o.run     <= wdata_i[CB_RUN];
               ctrl_o.hold    <= wdata_i[CB_HOLD];
               ctrl_o.act_hi  <= wdata_i[CB_ACTHI];
               ctrl_o.idle_hi <= wdata_i[CB_IDLEHI];
            end
            ADDR_W'(ADR_PERIOD): period_o <= wdata_i[CNT_W-1:0];
            ADDR_W'(ADR_DUTY):   duty_o   <= wdata_i[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(ADR_CTRL):   rdata_o[3:0] = ctrl_o;
         ADDR_W'(ADR_PERIOD): rdata_o = {{PAD_W{1'b0}}, period_o};
         ADDR_W'(ADR_DUTY):   rdata_o = {{PAD_W{1'b0}}, duty_o};
         default:             rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned PRESCALE = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick_o = run_i;
      end else begin : g_div
         localparam int unsigned PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] ps_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)               ps_q <= '0;
            else if (!run_i)           ps_q <= '0;
            else if (ps_q == PS_LAST)  ps_q <= '0;
            else                       ps_q <= ps_q + 1'b1;
         end

         assign tick_o = run_i && (ps_q == PS_LAST);
      end
   endgenerate
endmodule

// File: rtl/pwm_core.sv
module pwm_core
   import pwm_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  ctrl_t            ctrl_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] act_period_o,
   output logic [CNT_W-1:0] act_duty_o,
   output logic             act_hi_o,
   output logic             act_idle_o,
   output logic             wrap_o,
   output logic             pwm_o
);
   logic [CNT_W-1:0] last_cnt;
   logic             load;

   assign last_cnt = (act_period_o == '0) ? '0 : act_period_o - 1'b1;
   assign wrap_o   = (cnt_o >= last_cnt);
   assign load     = !ctrl_i.hold && (!ctrl_i.run || (tick_i && wrap_o));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_o <= '0;
      else if (!ctrl_i.run) cnt_o <= '0;
      else if (tick_i)      cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_period_o <= '0;
         act_duty_o   <= '0;
         act_hi_o     <= CTRL_RESET.act_hi;
         act_idle_o   <= CTRL_RESET.idle_hi;
      end else if (load) begin
         act_period_o <= period_i;
         act_duty_o   <= duty_i;
         act_hi_o     <= ctrl_i.act_hi;
         act_idle_o   <= ctrl_i.idle_hi;
      end
   end

   always_comb begin
      if (!ctrl_i.run)              pwm_o = act_idle_o;
      else if (cnt_o < act_duty_o)  pwm_o = act_hi_o;
      else                          pwm_o = !act_hi_o;
   end
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
   import pwm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned PRESCALE = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              pwm_o
);
   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover three registers");
      end
      if (DATA_W < CNT_W || DATA_W < 4) begin : g_bad_data
         $error("DATA_W must hold the counter and control fields");
      end
   endgenerate

   ctrl_t            stg_ctrl;
   logic [CNT_W-1:0] stg_period, stg_duty;
   logic [CNT_W-1:0] cnt, act_period, act_duty;
   logic             act_hi, act_idle, tick, wrap;

   pwm_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (bus_valid_i),
      .write_i  (bus_write_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .rdata_o  (bus_rdata_o),
      .ctrl_o   (stg_ctrl),
      .period_o (stg_period),
      .duty_o   (stg_duty)
   );

   pwm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (stg_ctrl.run),
      .tick_o (tick)
   );

   pwm_core #(.CNT_W(CNT_W)) u_core (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick),
      .ctrl_i       (stg_ctrl),
      .period_i     (stg_period),
      .duty_i       (stg_duty),
      .cnt_o        (cnt),
      .act_period_o (act_period),
      .act_duty_o   (act_duty),
      .act_hi_o     (act_hi),
      .act_idle_o   (act_idle),
      .wrap_o       (wrap),
      .pwm_o        (pwm_o)
   );
endmodule

// File: rtl/pwm_shadow_chan_chk.sv
module pwm_shadow_chan_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             run,
   input logic             hold,
   input logic             tick,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_period,
   input logic [CNT_W-1:0] act_duty,
   input logic             act_hi,
   input logic             act_idle,
   input logic             pwm_o
);
   logic [CNT_W-1:0] eff_last;
   assign eff_last = (act_period == '0) ? '0 : act_period - 1'b1;

   // R5: a stopped channel keeps its counter at zero
   a_r5_cnt_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> (cnt == '0) || run);

   // R5: stopped output equals the idle level
   a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> pwm_o == act_idle);

   // R3: counter never leaves the running period
   a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run |-> cnt <= eff_last);

   // R3: a tick at the last count returns the counter to zero
   a_r3_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && tick && wrap) |=> (cnt == '0));

   // R7: while held the running copy does not move
   a_r7_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold |=> $stable(act_period) && $stable(act_duty) && $stable(act_hi));

   // R6: no mid-period change of the running copy
   a_r6_no_midperiod: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && !(tick && wrap)) |=> $stable(act_period) && $stable(act_duty)
                                   && $stable(act_hi) && $stable(act_idle));

   // R4: zero duty never shows the active level
   a_r4_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && act_duty == '0) |-> pwm_o != act_hi);
endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .run        (stg_ctrl.run),
   .hold       (stg_ctrl.hold),
   .tick       (tick),
   .wrap       (wrap),
   .cnt        (cnt),
   .act_period (act_period),
   .act_duty   (act_duty),
   .act_hi     (act_hi),
   .act_idle   (act_idle),
   .pwm_o      (pwm_o)
);

// File: tb/pwm_shadow_chan_bench.sv
module pwm_shadow_chan_bench;
   localparam int P = 4;
   localparam int BIG = 1 << 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0, wr = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        pwm;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   int ws_k[4], ws_a[4], ws_d[4];
   int ws_n = 0;

   always #2.5 clk = ~clk;

   pwm_shadow_chan #(.ADDR_W(2), .DATA_W(16), .CNT_W(8), .PRESCALE(P)) u_pwm_shadow_chan (
      .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm));

   function automatic int cw(bit run, bit hold, bit ahi, bit ihi);
      return {28'd0, ihi, ahi, hold, run};
   endfunction

   function automatic bit lvl(int k, int per, int duty, bit ahi);
      int pe = (per == 0) ? 1 : per;
      return (((k / P) % pe) < duty) ? ahi : !ahi;
   endfunction

   function automatic int boundary(int w, int per);
      int m = ((per == 0) ? 1 : per) * P;
      return ((w + 2 + m - 1) / m) * m;
   endfunction

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_write(int a, int d);
      @(negedge clk);
      valid = 1'b1; wr = 1'b1; addr = 2'(a); wdata = 16'(d);
      @(posedge clk);
      #1 valid = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(string req, int a, int exp);
      @(negedge clk);
      valid = 1'b1; wr = 1'b0; addr = 2'(a);
      #1 check(req, int'(rdata), exp);
      valid = 1'b0;
   endtask

   // k counts clocks from the last write edge; staged writes ws_* are issued at cycle ws_k
   task automatic window(string req, int n, int pa, int da, bit ha,
                         int pb, int db, bit hb, int sk);
      for (int k = 0; k < n; k++) begin
         bit e;
         @(negedge clk);
         e = (k < sk) ? lvl(k, pa, da, ha) : lvl(k - sk, pb, db, hb);
         check(req, int'(pwm), int'(e));
         valid = 1'b0; wr = 1'b0;
         for (int i = 0; i < ws_n; i++) begin
            if (ws_k[i] == k) begin
               valid = 1'b1; wr = 1'b1; addr = 2'(ws_a[i]); wdata = 16'(ws_d[i]);
            end
         end
      end
      @(negedge clk);
      valid = 1'b0; wr = 1'b0;
      ws_n = 0;
   endtask

   task automatic start(int per, int duty, bit ahi);
      bus_write(0, cw(0, 0, ahi, !ahi));
      bus_write(1, per);
      bus_write(2, duty);
      bus_write(0, cw(1, 0, ahi, !ahi));
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got 0 expected 1 (run finished)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seed, sk;
      seed = $urandom(32'd24601);
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pwm", int'(pwm), 0);
      bus_read("R1 ctrl", 0, 4);
      bus_read("R1 period", 1, 0);
      bus_read("R1 duty", 2, 0);
      rst_n = 1'b1;
      bus_read("R1 after release", 0, 4);

      // R2 readback
      bus_write(1, 16'h00a5);
      bus_read("R2 period", 1, 16'h00a5);
      bus_write(2, 16'h0033);
      bus_read("R2 duty", 2, 16'h0033);
      bus_write(0, 16'hfff8);
      bus_read("R2 ctrl upper bits", 0, 8);
      bus_read("R2 addr3", 3, 0);

      // R3 basic waveform
      start(6, 2, 1);
      window("R3 basic", 6 * P * 2 + 3, 6, 2, 1, 0, 0, 0, BIG);
      // R3 period one and period zero
      start(1, 1, 1);
      window("R3 period one", 3 * P, 1, 1, 1, 0, 0, 0, BIG);
      start(0, 0, 1);
      window("R3 period zero", 3 * P, 0, 0, 1, 0, 0, 0, BIG);
      // R4 duty extremes
      start(5, 0, 1);
      window("R4 duty zero", 2 * 5 * P, 5, 0, 1, 0, 0, 0, BIG);
      start(5, 5, 1);
      window("R4 duty eq period", 2 * 5 * P, 5, 5, 1, 0, 0, 0, BIG);
      start(5, 9, 0);
      window("R4 duty above period", 2 * 5 * P, 5, 9, 0, 0, 0, 0, BIG);
      // R9 inverted polarity
      start(7, 3, 0);
      window("R9 inverted", 2 * 7 * P, 7, 3, 0, 0, 0, 0, BIG);

      // R5 stop: idle level, then clean restart
      bus_write(0, cw(0, 0, 0, 1));
      repeat (2) @(negedge clk);
      check("R5 idle high", int'(pwm), 1);
      bus_write(1, 9);
      @(negedge clk);
      check("R5 idle unaffected by period write", int'(pwm), 1);
      bus_write(0, cw(0, 0, 1, 0));
      repeat (2) @(negedge clk);
      check("R5 idle low", int'(pwm), 0);
      start(4, 2, 0);
      window("R5 restart", 2 * 4 * P, 4, 2, 0, 0, 0, 0, BIG);

      // R6 unlocked mid-period duty write
      start(5, 1, 1);
      ws_k[0] = 3; ws_a[0] = 2; ws_d[0] = 4; ws_n = 1;
      window("R6 mid-period", 3 * 5 * P, 5, 1, 1, 5, 4, 1, boundary(3, 5));
      // R6 write one clock before wrap waits a full period
      start(5, 1, 1);
      ws_k[0] = 5 * P - 1; ws_a[0] = 2; ws_d[0] = 3; ws_n = 1;
      sk = boundary(5 * P - 1, 5);
      check("R6 late boundary", sk, 10 * P);
      window("R6 late write", 4 * 5 * P, 5, 1, 1, 5, 3, 1, sk);
      // R6 write two clocks before wrap lands at that wrap
      start(5, 1, 1);
      ws_k[0] = 5 * P - 2; ws_a[0] = 2; ws_d[0] = 3; ws_n = 1;
      window("R6 early write", 3 * 5 * P, 5, 1, 1, 5, 3, 1, boundary(5 * P - 2, 5));

      // R7 / R8 hold, rewrite, release with polarity flip
      start(6, 2, 1);
      ws_k[0] = 5;  ws_a[0] = 0; ws_d[0] = cw(1, 1, 1, 0);
      ws_k[1] = 7;  ws_a[1] = 1; ws_d[1] = 4;
      ws_k[2] = 9;  ws_a[2] = 2; ws_d[2] = 3;
      ws_k[3] = 40; ws_a[3] = 0; ws_d[3] = cw(1, 0, 0, 1);
      ws_n = 4;
      sk = boundary(40, 6);
      window("R7 R8 hold then release", sk + 2 * 4 * P, 6, 2, 1, 4, 3, 0, sk);

      // Random configurations (R3 R4 R9)
      for (int it = 0; it < 24; it++) begin
         int per, duty;
         bit ahi;
         per  = 1 + int'($urandom % 10);
         duty = int'($urandom % (per + 3));
         ahi  = 1'($urandom % 2);
         start(per, duty, ahi);
         window("R3 R4 R9 random", 2 * per * P + 3, per, duty, ahi, 0, 0, 0, BIG);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule